// File: doc/BRIEF.md
# Dithered First-Order Integer Low-Pass Filter

This block smooths a stream of signed integer samples with a single-pole low-pass recursion. On every accepted sample the held output moves toward the input by one a-th of the gap, where a is a power of two fixed at build time. Plain integer truncation of that step leaves the output parked short of a constant input. A small non-negative dither term, always below a, is therefore added to the gap before the shift, so the output can land exactly on the input.

The dither source is picked per sample by a two-bit mode input. It can be a free-running counter that cycles through 0..a-1, a carried remainder from the previous update (delta-sigma style), the top bits of an 8-bit pseudorandom register, or nothing at all. The filtered value is presented one clock after each accepted sample, together with a valid strobe.

Top module: `iirdith_filter`

## Requirements
- R1: While reset is asserted (rst_n low), out_data is 0 and out_valid is 0. Reset also clears the step counter and the carried remainder to 0 and loads the pseudorandom register with 0x01.
- R2: out_valid equals in_valid delayed by one clock. out_data changes only in the cycle after an accepted sample and otherwise holds its value.
- R3: Mode 3 (no dither) computes out = out + floor((in − out) / a). For a = 4 and a step from 0 to 16, the output settles at 13, which is a−1 counts short of the input.
- R4: Mode 0 uses the step counter as the dither. The counter advances by one modulo a on every accepted sample in every mode.
- R5: Mode 1 forms t = rem + in − out, updates out = out + floor(t / a), and stores rem = t mod a, which is the low log2(a) bits of t in two's complement. In the other modes rem holds its value.
- R6: Mode 2 uses the top log2(a) bits of the pseudorandom register as the dither, which equals floor(a·r/256). The register shifts left, taking s7^s5^s4^s3 into bit 0, once per accepted sample in every mode.
- R7: For a = 4 and a step from 0 to 16, each of modes 0, 1 and 2 reaches an output of exactly 16 and stays there. An accepted sample equal to the current output leaves the output unchanged.
- R8: An accepted sample never moves the output past the input or away from it. Full-scale swings between the most positive and the most negative input never wrap the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe |
| in_data | input | DW | Signed input sample |
| mode | input | 2 | Dither select: 0 counter, 1 remainder, 2 pseudorandom, 3 none |
| out_valid | output | 1 | Filtered value strobe |
| out_data | output | DW | Signed filtered value |

## Verification
The properties assume that mode and in_data are meaningful only while in_valid is high and that reset is applied before the first sample. They also assume that a is no larger than 16, so the pseudorandom top bits exist. The stimulus changes inputs only on the falling edge. It applies reset between each settling run so that every run starts from zero, and it uses the default a = 4. Its full-scale and mixed-mode runs keep in_data inside the signed range of DW.

// File: rtl/iirdith_pkg.sv
package iirdith_pkg;
    typedef enum logic [1:0] {
        DM_COUNT  = 2'd0,
        DM_REMAIN = 2'd1,
        DM_RANDOM = 2'd2,
        DM_NONE   = 2'd3
    } dmode_e;

    localparam logic [7:0] LFSR_SEED = 8'h01;
endpackage

// File: rtl/iirdith_lfsr.sv
module iirdith_lfsr #(
    parameter logic [7:0] SEED = 8'h01
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       adv,
    output logic [7:0] state
);
    typedef struct packed {
        logic [7:0] sr;
    } lfsr_st_t;

    lfsr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adv) begin
            st_d.sr = {st_q.sr[6:0], st_q.sr[7] ^ st_q.sr[5] ^ st_q.sr[4] ^ st_q.sr[3]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{sr: SEED};
        else        st_q <= st_d;
    end

    assign state = st_q.sr;
endmodule

// File: rtl/iirdith_dither_sel.sv
module iirdith_dither_sel
    import iirdith_pkg::*;
#(
    parameter int K = 2
) (
    input  logic [1:0]   mode,
    input  logic [K-1:0] cnt,
    input  logic [K-1:0] rem,
    input  logic [K-1:0] rnd_top,
    output logic [K-1:0] dith
);
    always_comb begin
        unique case (dmode_e'(mode))
            DM_COUNT:  dith = cnt;
            DM_REMAIN: dith = rem;
            DM_RANDOM: dith = rnd_top;
            default:   dith = '0;
        endcase
    end
endmodule

// File: rtl/iirdith_update.sv
module iirdith_update #(
    parameter int DW = 16,
    parameter int K  = 2
) (
    input  logic signed [DW-1:0] in_s,
    input  logic signed [DW-1:0] cur,
    input  logic        [K-1:0]  dith,
    output logic signed [DW-1:0] nxt,
    output logic        [K-1:0]  rem_nxt
);
    localparam int W = DW + K + 1;

    logic signed [W-1:0] in_x, cur_x, dith_x, gap, step, sum;

    always_comb begin
        in_x   = W'(in_s);
        cur_x  = W'(cur);
        dith_x = W'($signed({1'b0, dith}));
        gap    = in_x - cur_x + dith_x;
        step   = gap >>> K;
        sum    = cur_x + step;
        nxt    = sum[DW-1:0];
        rem_nxt = gap[K-1:0];
    end
endmodule

// File: rtl/iirdith_filter.sv
module iirdith_filter
    import iirdith_pkg::*;
#(
    parameter int DW = 16,
    parameter int K  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_data,
    input  logic [1:0]           mode,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_data
);
    typedef struct packed {
        logic                 vld;
        logic signed [DW-1:0] acc;
        logic [K-1:0]         cnt;
        logic [K-1:0]         rem;
    } flt_st_t;

    flt_st_t st_d, st_q;

    logic [7:0]           rnd;
    logic [K-1:0]         dith;
    logic signed [DW-1:0] acc_nxt;
    logic [K-1:0]         rem_nxt;

    iirdith_lfsr #(.SEED(LFSR_SEED)) lfsr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (in_valid),
        .state (rnd)
    );

    iirdith_dither_sel #(.K(K)) sel_i (
        .mode    (mode),
        .cnt     (st_q.cnt),
        .rem     (st_q.rem),
        .rnd_top (rnd[7 -: K]),
        .dith    (dith)
    );

    iirdith_update #(.DW(DW), .K(K)) upd_i (
        .in_s    (in_data),
        .cur     (st_q.acc),
        .dith    (dith),
        .nxt     (acc_nxt),
        .rem_nxt (rem_nxt)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.acc = acc_nxt;
            st_d.cnt = st_q.cnt + K'(1);
            if (dmode_e'(mode) == DM_REMAIN) st_d.rem = rem_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.acc;
endmodule

// File: rtl/iirdith_chk.sv
module iirdith_chk #(
    parameter int DW = 16,
    parameter int K  = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic signed [DW-1:0] in_data,
    input logic [1:0]           mode,
    input logic                 out_valid,
    input logic signed [DW-1:0] out_data
);
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_data)));
    a_r7_fixed_point: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_data == out_data) |=> $stable(out_data));
    a_r8_no_overshoot_up: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_data > out_data) |=>
        (out_data >= $past(out_data) && out_data <= $past(in_data)));
    a_r8_no_overshoot_down: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_data < out_data) |=>
        (out_data <= $past(out_data) && out_data >= $past(in_data)));
    a_r6_mode_known: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> !$isunknown(mode));
endmodule

bind iirdith_filter iirdith_chk #(.DW(DW), .K(K)) chk_i (.*);

// File: tb/iirdith_filter_tb.sv
module iirdith_filter_tb_top;
    localparam int DW = 16;
    localparam int K  = 2;
    localparam int A  = 1 << K;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic signed [DW-1:0] in_data = '0;
    logic [1:0]           mode = 2'd0;
    logic                 out_valid;
    logic signed [DW-1:0] out_data;

    int n_total = 0;
    int n_bad   = 0;
    bit done    = 0;

    longint m_out;
    int     m_cnt, m_rem;
    logic [7:0] m_lfsr;
    longint exp_q[$];

    always #2.5 clk = ~clk;

    iirdith_filter #(.DW(DW), .K(K)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .mode(mode), .out_valid(out_valid), .out_data(out_data)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_total++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_out = 0; m_cnt = 0; m_rem = 0; m_lfsr = 8'h01;
    endtask

    // reference model built from R3..R6
    task automatic model_step(input longint x, input int m);
        longint d, t;
        case (m)
            0: d = m_cnt;
            1: d = m_rem;
            2: d = longint'(m_lfsr) / (256 / A);
            default: d = 0;
        endcase
        t = d + x - m_out;
        m_out = m_out + (t >>> K);
        if (m == 1) m_rem = int'(t & (A - 1));
        m_cnt = (m_cnt + 1) % A;
        m_lfsr = {m_lfsr[6:0], m_lfsr[7] ^ m_lfsr[5] ^ m_lfsr[4] ^ m_lfsr[3]};
    endtask

    task automatic do_reset();
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        exp_q.delete();
        model_reset();
        @(negedge clk);
        chk(out_data == 0 && out_valid == 0, "R1 reset outputs", out_data, 0);
        rst_n = 1'b1;
    endtask

    task automatic send(input longint x, input int m);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = DW'(x);
        mode     = 2'(m);
        model_step(x, m);
        exp_q.push_back(m_out);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                chk(0, "R2 unexpected out_valid", 1, 0);
            end else begin
                longint e;
                e = exp_q.pop_front();
                chk(out_data == DW'(e), "R3-model output (R4 R5 R6 R8)", out_data, e);
            end
        end
    end

    task automatic step_run(input int m, input int n, input string req, input longint fin);
        do_reset();
        for (int i = 0; i < n; i++) send(16, m);
        idle(2);
        chk(out_data == fin, req, out_data, fin);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            chk(0, "watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        do_reset();

        // R3: undithered step stalls a-1 short
        step_run(3, 12, "R3 undithered settles at 13", 13);
        // R4 / R7: counter dither converges
        step_run(0, 40, "R4 R7 counter reaches 16", 16);
        // R5 / R7: remainder dither converges
        step_run(1, 40, "R5 R7 remainder reaches 16", 16);
        // R6 / R7: pseudorandom dither converges
        step_run(2, 120, "R6 R7 pseudorandom reaches 16", 16);

        // R7: equal input holds output
        for (int m = 0; m < 3; m++) send(16, m);
        idle(2);
        chk(out_data == 16, "R7 fixed point holds", out_data, 16);

        // R2: idle cycles keep valid low and value held
        begin
            logic signed [DW-1:0] held;
            send(-40, 0);
            idle(1);
            held = out_data;
            idle(3);
            chk(out_valid == 0, "R2 valid low when idle", out_valid, 0);
            chk(out_data == held, "R2 value held when idle", out_data, held);
        end

        // R5: remainder held across other modes, then reused
        do_reset();
        send(7, 1); send(7, 1); send(30, 0); send(30, 2); send(30, 1); send(30, 1);
        idle(2);
        chk(out_data == DW'(m_out), "R5 remainder reused after other modes", out_data, m_out);

        // R8: full-scale swings
        do_reset();
        for (int i = 0; i < 40; i++) begin
            longint x;
            x = (i % 8 < 4) ? 32767 : -32768;
            send(x, i % 4);
        end
        idle(2);
        chk(out_data >= -32768 && out_data <= 32767 && out_data == DW'(m_out),
            "R8 full-scale no wrap", out_data, m_out);

        // mixed random stimulus with gaps
        for (int i = 0; i < 150; i++) begin
            if ($urandom_range(0, 3) == 0) idle(1);
            else send(longint'($signed(16'($urandom()))), int'($urandom_range(0, 3)));
        end
        idle(3);
        chk(exp_q.size() == 0, "R2 every sample produced a result", exp_q.size(), 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end
endmodule